// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Unit

This block sits beside one processor and decides whether an interrupt offered by the source side is delivered to it. It keeps a current processor priority value. It holds at most one presented device interrupt in a single slot, and it also holds a pending flag for a per-processor inter-processor interrupt (IPI). Priorities are 8 bits wide, and a numerically smaller value is more favored. A candidate is delivered only when it is strictly more favored than the current processor priority. An interrupt that stops being eligible is handed back to its source so that the source can retry it later.

The processor uses three operations. An accept read takes the presented interrupt. It returns the previous processor priority and the source number, raises the processor priority to the priority of the accepted interrupt, and holds that source in service until end-of-interrupt. An end-of-interrupt write releases a source. Its priority field can only make the processor priority less favored. A plain priority write sets the processor priority directly. Software uses it either to reopen delivery at the same level before service ends, or to push a presented interrupt back to its source.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the processor priority reads 0x00, `irq_o` is low, all return, decline and release pulses are low, and the accept outputs are zero. With priority 0x00 every offer is declined.
- R2: An offer is captured only if its priority is numerically smaller than the processor priority. Otherwise it is declined with `nak_valid_o` and `nak_src_o` one cycle later. At priority 0xFF an offer at 0xFE is captured and an offer at 0xFF is declined.
- R3: `irq_o` is a registered level. It rises one cycle after an eligible interrupt is captured, and it falls at the clock edge that samples the accept read or the return, unless another eligible interrupt remains.
- R4: An accept read while `irq_o` is high loads `acc_prev_o` with the old processor priority and `acc_src_o` with the source number. The processor priority becomes the accepted priority, and the source is marked in service. All three are visible one cycle later.
- R5: An accept read with nothing presentable returns source 0, returns the current priority as the previous priority, and leaves the processor priority unchanged.
- R6: An offer is declined if it comes from source 0, from the IPI source number, from a source that is in service, or from the source that already occupies the slot.
- R7: An end-of-interrupt write sets the processor priority to the written value only when that value is numerically greater than or equal to the current one. Otherwise the priority is unchanged and nothing is returned. If the written source is in service, it is released with a one-cycle `rel_valid_o` pulse carrying that source number.
- R8: Whenever the processor priority changes (priority write, accept or end-of-interrupt) so that the held slot interrupt is no longer strictly more favored, the slot is emptied and its source is returned on `rtn_valid_o` and `rtn_src_o` one cycle later.
- R9: An eligible offer that is strictly more favored than the occupied slot replaces it, and the old occupant is returned. An eligible offer that is equal or less favored than the occupant is declined.
- R10: `ipi_req_i` sets the IPI pending flag. The IPI is presentable while its priority `IPI_PRIO` is more favored than the processor priority and the IPI is not in service. It wins an accept against a slot interrupt of equal or less favored priority. It is never returned, and its source number is `IPI_SRC`.
- R11: Only one processor operation is honored per cycle, with the precedence accept, then end-of-interrupt, then priority write. The losing operations have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid_i | input | 1 | Source side offers a candidate this cycle |
| offer_src_i | input | SRC_W | Source number of the offer |
| offer_prio_i | input | PRIO_W | Priority of the offer |
| nak_valid_o | output | 1 | Offer declined (one-cycle pulse) |
| nak_src_o | output | SRC_W | Declined source number, 0 when idle |
| rtn_valid_o | output | 1 | Presented interrupt returned to its source |
| rtn_src_o | output | SRC_W | Returned source number, 0 when idle |
| rel_valid_o | output | 1 | In-service source released by end-of-interrupt |
| rel_src_o | output | SRC_W | Released source number, 0 when idle |
| ipi_req_i | input | 1 | Inter-processor interrupt request |
| irq_o | output | 1 | Interrupt presentation level to the processor |
| acc_rd_i | input | 1 | Accept read strobe |
| acc_prev_o | output | PRIO_W | Processor priority before the last accept |
| acc_src_o | output | SRC_W | Source number from the last accept (0 = none) |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| eoi_prio_i | input | PRIO_W | Priority to restore at end-of-interrupt |
| eoi_src_i | input | SRC_W | Source to release at end-of-interrupt |
| pri_wr_i | input | 1 | Processor priority write strobe |
| pri_data_i | input | PRIO_W | New processor priority |
| cur_pri_o | output | PRIO_W | Current processor priority |

## Verification
Every result of this block comes from a register, so each output is due exactly one cycle after the edge that samples its stimulus. The presentation level, the processor priority, the decline, return and release pulses, and the accept fields all follow that rule. The bench drives inputs just after a falling edge and lets one rising edge pass. At the next falling edge it compares every output with a bench model that has been advanced by exactly one step for the same inputs. The directed steps put extra checks on those same sample points: strict comparison at 0xFF, an empty accept, a raise attempt at end-of-interrupt, return after a priority write, displacement, IPI preference and operation precedence.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    typedef enum logic [1:0] {
        CPU_IDLE   = 2'd0,
        CPU_ACCEPT = 2'd1,
        CPU_EOI    = 2'd2,
        CPU_SETPRI = 2'd3
    } cpu_op_e;

endpackage

// File: rtl/ipu_accept_sel.sv
// Chooses which presentable interrupt an accept read would take.
module ipu_accept_sel #(
    parameter int                SRC_W    = 4,
    parameter int                PRIO_W   = 8,
    parameter logic [PRIO_W-1:0] IPI_PRIO = 8'h02,
    parameter logic [SRC_W-1:0]  IPI_SRC  = 4'd1
) (
    input  logic [PRIO_W-1:0] cppr_i,
    input  logic              slot_v_i,
    input  logic [SRC_W-1:0]  slot_src_i,
    input  logic [PRIO_W-1:0] slot_prio_i,
    input  logic              ipi_pend_i,
    input  logic              ipi_busy_i,
    output logic              take_ipi_o,
    output logic              take_slot_o,
    output logic              any_o,
    output logic [SRC_W-1:0]  sel_src_o,
    output logic [PRIO_W-1:0] sel_prio_o
);
    logic ipi_ok;
    logic slot_ok;

    always_comb begin
        ipi_ok      = ipi_pend_i && !ipi_busy_i && (IPI_PRIO < cppr_i);
        slot_ok     = slot_v_i && (slot_prio_i < cppr_i);
        take_ipi_o  = ipi_ok && (!slot_ok || (IPI_PRIO <= slot_prio_i));
        take_slot_o = slot_ok && !take_ipi_o;
        any_o       = take_ipi_o || take_slot_o;
        sel_src_o   = '0;
        sel_prio_o  = cppr_i;
        if (take_ipi_o) begin
            sel_src_o  = IPI_SRC;
            sel_prio_o = IPI_PRIO;
        end else if (take_slot_o) begin
            sel_src_o  = slot_src_i;
            sel_prio_o = slot_prio_i;
        end
    end
endmodule

// File: rtl/ipu_cpu_ops.sv
// Decodes the processor-side operation and the next processor priority.
module ipu_cpu_ops
    import ipu_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              acc_rd_i,
    input  logic              eoi_wr_i,
    input  logic [PRIO_W-1:0] eoi_prio_i,
    input  logic              pri_wr_i,
    input  logic [PRIO_W-1:0] pri_data_i,
    input  logic [PRIO_W-1:0] cppr_i,
    input  logic              any_i,
    input  logic [PRIO_W-1:0] sel_prio_i,
    output cpu_op_e           op_o,
    output logic [PRIO_W-1:0] cppr_next_o
);
    always_comb begin
        if (acc_rd_i)       op_o = CPU_ACCEPT;
        else if (eoi_wr_i)  op_o = CPU_EOI;
        else if (pri_wr_i)  op_o = CPU_SETPRI;
        else                op_o = CPU_IDLE;

        cppr_next_o = cppr_i;
        unique case (op_o)
            CPU_ACCEPT: if (any_i) cppr_next_o = sel_prio_i;
            CPU_EOI:    if (eoi_prio_i > cppr_i) cppr_next_o = eoi_prio_i;
            CPU_SETPRI: cppr_next_o = pri_data_i;
            default:    cppr_next_o = cppr_i;
        endcase
    end
endmodule

// File: rtl/ipu_slot_ctl.sv
// Keeps the single presented device slot consistent with the priority and offers.
module ipu_slot_ctl #(
    parameter int               SRC_W   = 4,
    parameter int               PRIO_W  = 8,
    parameter logic [SRC_W-1:0] IPI_SRC = 4'd1
) (
    input  logic [PRIO_W-1:0] cppr_next_i,
    input  logic              slot_v_i,
    input  logic [SRC_W-1:0]  slot_src_i,
    input  logic [PRIO_W-1:0] slot_prio_i,
    input  logic              offer_valid_i,
    input  logic [SRC_W-1:0]  offer_src_i,
    input  logic [PRIO_W-1:0] offer_prio_i,
    input  logic              offer_busy_i,
    output logic              slot_v_o,
    output logic [SRC_W-1:0]  slot_src_o,
    output logic [PRIO_W-1:0] slot_prio_o,
    output logic              nak_o,
    output logic [SRC_W-1:0]  nak_src_o,
    output logic              rtn_o,
    output logic [SRC_W-1:0]  rtn_src_o
);
    logic offer_bad;

    always_comb begin
        slot_v_o    = slot_v_i;
        slot_src_o  = slot_src_i;
        slot_prio_o = slot_prio_i;
        nak_o       = 1'b0;
        nak_src_o   = '0;
        rtn_o       = 1'b0;
        rtn_src_o   = '0;

        // a priority change may leave the slot no longer admissible
        if (slot_v_o && (slot_prio_o >= cppr_next_i)) begin
            rtn_o     = 1'b1;
            rtn_src_o = slot_src_o;
            slot_v_o  = 1'b0;
        end

        offer_bad = (offer_src_i == '0) || (offer_src_i == IPI_SRC) || offer_busy_i
                 || (slot_v_o && (offer_src_i == slot_src_o))
                 || (offer_prio_i >= cppr_next_i);

        if (offer_valid_i) begin
            if (offer_bad) begin
                nak_o     = 1'b1;
                nak_src_o = offer_src_i;
            end else if (!slot_v_o) begin
                slot_v_o    = 1'b1;
                slot_src_o  = offer_src_i;
                slot_prio_o = offer_prio_i;
            end else if (offer_prio_i < slot_prio_o) begin
                rtn_o       = 1'b1;
                rtn_src_o   = slot_src_o;
                slot_src_o  = offer_src_i;
                slot_prio_o = offer_prio_i;
            end else begin
                nak_o     = 1'b1;
                nak_src_o = offer_src_i;
            end
        end
    end
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit
    import ipu_pkg::*;
#(
    parameter int                SRC_W    = 4,
    parameter int                PRIO_W   = 8,
    parameter logic [PRIO_W-1:0] IPI_PRIO = 8'h02,
    parameter logic [SRC_W-1:0]  IPI_SRC  = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              offer_valid_i,
    input  logic [SRC_W-1:0]  offer_src_i,
    input  logic [PRIO_W-1:0] offer_prio_i,
    output logic              nak_valid_o,
    output logic [SRC_W-1:0]  nak_src_o,
    output logic              rtn_valid_o,
    output logic [SRC_W-1:0]  rtn_src_o,
    output logic              rel_valid_o,
    output logic [SRC_W-1:0]  rel_src_o,
    input  logic              ipi_req_i,
    output logic              irq_o,
    input  logic              acc_rd_i,
    output logic [PRIO_W-1:0] acc_prev_o,
    output logic [SRC_W-1:0]  acc_src_o,
    input  logic              eoi_wr_i,
    input  logic [PRIO_W-1:0] eoi_prio_i,
    input  logic [SRC_W-1:0]  eoi_src_i,
    input  logic              pri_wr_i,
    input  logic [PRIO_W-1:0] pri_data_i,
    output logic [PRIO_W-1:0] cur_pri_o
);
    localparam int NSRC = 1 << SRC_W;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic              slot_v;
        logic [SRC_W-1:0]  slot_src;
        logic [PRIO_W-1:0] slot_prio;
        logic              ipi_pend;
        logic [NSRC-1:0]   insvc;
        logic              irq;
        logic              nak_v;
        logic [SRC_W-1:0]  nak_src;
        logic              rtn_v;
        logic [SRC_W-1:0]  rtn_src;
        logic              rel_v;
        logic [SRC_W-1:0]  rel_src;
        logic [PRIO_W-1:0] acc_prev;
        logic [SRC_W-1:0]  acc_src;
    } state_t;

    state_t st_q, st_d;

    logic              take_ipi, take_slot, sel_any;
    logic [SRC_W-1:0]  sel_src;
    logic [PRIO_W-1:0] sel_prio;
    cpu_op_e           cpu_op;
    logic [PRIO_W-1:0] cppr_next;
    logic              do_accept, do_release;
    logic [NSRC-1:0]   insvc_mid;
    logic              mid_slot_v;
    logic              nx_slot_v, nx_nak, nx_rtn;
    logic [SRC_W-1:0]  nx_slot_src, nx_nak_src, nx_rtn_src;
    logic [PRIO_W-1:0] nx_slot_prio;
    logic              ipi_pend_mid;

    ipu_accept_sel #(
        .SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_PRIO(IPI_PRIO), .IPI_SRC(IPI_SRC)
    ) u_sel (
        .cppr_i      (st_q.cppr),
        .slot_v_i    (st_q.slot_v),
        .slot_src_i  (st_q.slot_src),
        .slot_prio_i (st_q.slot_prio),
        .ipi_pend_i  (st_q.ipi_pend),
        .ipi_busy_i  (st_q.insvc[IPI_SRC]),
        .take_ipi_o  (take_ipi),
        .take_slot_o (take_slot),
        .any_o       (sel_any),
        .sel_src_o   (sel_src),
        .sel_prio_o  (sel_prio)
    );

    ipu_cpu_ops #(.PRIO_W(PRIO_W)) u_ops (
        .acc_rd_i    (acc_rd_i),
        .eoi_wr_i    (eoi_wr_i),
        .eoi_prio_i  (eoi_prio_i),
        .pri_wr_i    (pri_wr_i),
        .pri_data_i  (pri_data_i),
        .cppr_i      (st_q.cppr),
        .any_i       (sel_any),
        .sel_prio_i  (sel_prio),
        .op_o        (cpu_op),
        .cppr_next_o (cppr_next)
    );

    // in-service set and slot occupancy after this cycle's processor operation
    always_comb begin
        do_accept    = (cpu_op == CPU_ACCEPT);
        do_release   = (cpu_op == CPU_EOI) && (eoi_src_i != '0) && st_q.insvc[eoi_src_i];
        insvc_mid    = st_q.insvc;
        if (do_accept && sel_any) insvc_mid[sel_src] = 1'b1;
        if (do_release)           insvc_mid[eoi_src_i] = 1'b0;
        mid_slot_v   = st_q.slot_v && !(do_accept && take_slot);
        ipi_pend_mid = (st_q.ipi_pend && !(do_accept && take_ipi)) || ipi_req_i;
    end

    ipu_slot_ctl #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_slot (
        .cppr_next_i   (cppr_next),
        .slot_v_i      (mid_slot_v),
        .slot_src_i    (st_q.slot_src),
        .slot_prio_i   (st_q.slot_prio),
        .offer_valid_i (offer_valid_i),
        .offer_src_i   (offer_src_i),
        .offer_prio_i  (offer_prio_i),
        .offer_busy_i  (insvc_mid[offer_src_i]),
        .slot_v_o      (nx_slot_v),
        .slot_src_o    (nx_slot_src),
        .slot_prio_o   (nx_slot_prio),
        .nak_o         (nx_nak),
        .nak_src_o     (nx_nak_src),
        .rtn_o         (nx_rtn),
        .rtn_src_o     (nx_rtn_src)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cppr      = cppr_next;
        st_d.slot_v    = nx_slot_v;
        st_d.slot_src  = nx_slot_src;
        st_d.slot_prio = nx_slot_prio;
        st_d.ipi_pend  = ipi_pend_mid;
        st_d.insvc     = insvc_mid;
        st_d.nak_v     = nx_nak;
        st_d.nak_src   = nx_nak_src;
        st_d.rtn_v     = nx_rtn;
        st_d.rtn_src   = nx_rtn_src;
        st_d.rel_v     = do_release;
        st_d.rel_src   = do_release ? eoi_src_i : '0;
        if (do_accept) begin
            st_d.acc_prev = st_q.cppr;
            st_d.acc_src  = sel_src;
        end
        st_d.irq = nx_slot_v
                || (ipi_pend_mid && !insvc_mid[IPI_SRC] && (IPI_PRIO < cppr_next));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o       = st_q.irq;
    assign cur_pri_o   = st_q.cppr;
    assign nak_valid_o = st_q.nak_v;
    assign nak_src_o   = st_q.nak_src;
    assign rtn_valid_o = st_q.rtn_v;
    assign rtn_src_o   = st_q.rtn_src;
    assign rel_valid_o = st_q.rel_v;
    assign rel_src_o   = st_q.rel_src;
    assign acc_prev_o  = st_q.acc_prev;
    assign acc_src_o   = st_q.acc_src;
endmodule

// File: rtl/ipu_checker.sv
module ipu_checker #(
    parameter int SRC_W  = 4,
    parameter int PRIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              offer_valid_i,
    input logic              acc_rd_i,
    input logic              eoi_wr_i,
    input logic [PRIO_W-1:0] eoi_prio_i,
    input logic              irq_o,
    input logic [PRIO_W-1:0] cur_pri_o,
    input logic [PRIO_W-1:0] acc_prev_o,
    input logic [SRC_W-1:0]  acc_src_o,
    input logic              rtn_valid_o,
    input logic [SRC_W-1:0]  rtn_src_o
);
    // R2: something is presented only when a strictly more favored level exists
    p_irq_needs_pri_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cur_pri_o != '0));

    // R4: the accept reports the priority held before it
    p_accept_prev_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd_i |=> (acc_prev_o == $past(cur_pri_o)));

    // R4: a real accept names a source and makes the priority more favored
    p_accept_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd_i && irq_o) |=> ((acc_src_o != '0) && (cur_pri_o < $past(cur_pri_o))));

    // R5: accept with nothing presented
    p_empty_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd_i && !irq_o) |=> ((acc_src_o == '0) && $stable(cur_pri_o)));

    // R7: a raise request at end-of-interrupt changes nothing and returns nothing
    p_eoi_no_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr_i && !acc_rd_i && !offer_valid_i && (eoi_prio_i < cur_pri_o))
        |=> ($stable(cur_pri_o) && !rtn_valid_o));

    // R8: a returned interrupt always names a real source
    p_rtn_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rtn_valid_o |-> (rtn_src_o != '0));
endmodule

bind irq_present_unit ipu_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipu_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .offer_valid_i (offer_valid_i),
    .acc_rd_i      (acc_rd_i),
    .eoi_wr_i      (eoi_wr_i),
    .eoi_prio_i    (eoi_prio_i),
    .irq_o         (irq_o),
    .cur_pri_o     (cur_pri_o),
    .acc_prev_o    (acc_prev_o),
    .acc_src_o     (acc_src_o),
    .rtn_valid_o   (rtn_valid_o),
    .rtn_src_o     (rtn_src_o)
);

// File: tb/tb_irq_present_unit.sv
module tb_irq_present_unit;
    localparam int         SW = 4;
    localparam int         PW = 8;
    localparam logic [7:0] IPI_P = 8'h02;
    localparam logic [3:0] IPI_S = 4'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          ov = 0, ar = 0, ew = 0, pw = 0, ir = 0;
    logic [SW-1:0] os = 0, es = 0;
    logic [PW-1:0] op = 0, ep = 0, pd = 0;

    logic          nak_v, rtn_v, rel_v, irq;
    logic [SW-1:0] nak_s, rtn_s, rel_s, acc_s;
    logic [PW-1:0] acc_p, cur_p;

    irq_present_unit dut (
        .clk(clk), .rst_n(rst_n),
        .offer_valid_i(ov), .offer_src_i(os), .offer_prio_i(op),
        .nak_valid_o(nak_v), .nak_src_o(nak_s),
        .rtn_valid_o(rtn_v), .rtn_src_o(rtn_s),
        .rel_valid_o(rel_v), .rel_src_o(rel_s),
        .ipi_req_i(ir), .irq_o(irq),
        .acc_rd_i(ar), .acc_prev_o(acc_p), .acc_src_o(acc_s),
        .eoi_wr_i(ew), .eoi_prio_i(ep), .eoi_src_i(es),
        .pri_wr_i(pw), .pri_data_i(pd), .cur_pri_o(cur_p)
    );

    int nchk = 0, nerr = 0;

    // bench model state
    logic [7:0]  m_c, m_sp, e_ap;
    logic        m_sv, m_ipi;
    logic [3:0]  m_ss, e_as, e_ns, e_rs, e_ls;
    logic [15:0] m_ins;
    logic        e_irq, e_nak, e_rtn, e_rel;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_c = 0; m_sv = 0; m_ss = 0; m_sp = 0; m_ipi = 0; m_ins = 0;
        e_irq = 0; e_nak = 0; e_rtn = 0; e_rel = 0;
        e_ns = 0; e_rs = 0; e_ls = 0; e_ap = 0; e_as = 0;
    endtask

    task automatic model_step();
        logic ipi_ok, slot_ok, t_ipi, t_slot, bad;
        logic [7:0] nc;
        nc = m_c;
        ipi_ok  = m_ipi && !m_ins[IPI_S] && (IPI_P < m_c);
        slot_ok = m_sv && (m_sp < m_c);
        t_ipi   = ipi_ok && (!slot_ok || IPI_P <= m_sp);
        t_slot  = slot_ok && !t_ipi;
        e_nak = 0; e_rtn = 0; e_rel = 0; e_ns = 0; e_rs = 0; e_ls = 0;
        if (ar) begin
            e_ap = m_c;
            if (t_ipi) begin e_as = IPI_S; nc = IPI_P; m_ins[IPI_S] = 1; m_ipi = 0; end
            else if (t_slot) begin e_as = m_ss; nc = m_sp; m_ins[m_ss] = 1; m_sv = 0; end
            else e_as = 0;
        end else if (ew) begin
            if (ep > m_c) nc = ep;
            if (es != 0 && m_ins[es]) begin m_ins[es] = 0; e_rel = 1; e_ls = es; end
        end else if (pw) nc = pd;
        if (ir) m_ipi = 1;
        if (m_sv && m_sp >= nc) begin e_rtn = 1; e_rs = m_ss; m_sv = 0; end
        if (ov) begin
            bad = (os == 0) || (os == IPI_S) || m_ins[os] || (m_sv && os == m_ss) || (op >= nc);
            if (bad) begin e_nak = 1; e_ns = os; end
            else if (!m_sv) begin m_sv = 1; m_ss = os; m_sp = op; end
            else if (op < m_sp) begin e_rtn = 1; e_rs = m_ss; m_ss = os; m_sp = op; end
            else begin e_nak = 1; e_ns = os; end
        end
        m_c = nc;
        e_irq = m_sv || (m_ipi && !m_ins[IPI_S] && IPI_P < nc);
    endtask

    task automatic idle();
        ov = 0; ar = 0; ew = 0; pw = 0; ir = 0;
        os = 0; op = 0; es = 0; ep = 0; pd = 0;
    endtask

    // apply current inputs for one edge, then compare every output with the model
    task automatic step();
        model_step();
        @(negedge clk);
        chk(irq == e_irq, "R3 irq", irq, e_irq);
        chk(cur_p == m_c, "R4 priority", cur_p, m_c);
        chk(nak_v == e_nak && (!e_nak || nak_s == e_ns), "R2 decline", {nak_v, nak_s}, {e_nak, e_ns});
        chk(rtn_v == e_rtn && (!e_rtn || rtn_s == e_rs), "R8 return", {rtn_v, rtn_s}, {e_rtn, e_rs});
        chk(rel_v == e_rel && (!e_rel || rel_s == e_ls), "R7 release", {rel_v, rel_s}, {e_rel, e_ls});
        chk(acc_p == e_ap && acc_s == e_as, "R5 accept fields", {acc_p, acc_s}, {e_ap, e_as});
        idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        model_reset();
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 0 && cur_p == 0 && acc_s == 0 && acc_p == 0, "R1 reset", {irq, cur_p}, 0);
        chk(!nak_v && !rtn_v && !rel_v, "R1 pulses", {nak_v, rtn_v, rel_v}, 0);
        ov = 1; os = 3; op = 8'h05; step();
        chk(nak_v && nak_s == 3, "R1 priority 0 blocks", nak_v, 1);
        pw = 1; pd = 8'hFF; step();
        ov = 1; os = 3; op = 8'hFF; step();
        chk(nak_v == 1, "R2 equal level declined", nak_v, 1);
        ov = 1; os = 4; op = 8'hFE; step();
        chk(irq == 1, "R2 0xFE admitted at 0xFF", irq, 1);
        ar = 1; step();
        chk(acc_s == 4 && acc_p == 8'hFF && cur_p == 8'hFE, "R4 accept", {acc_p, acc_s}, {8'hFF, 4'd4});
        chk(irq == 0, "R3 falls on accept", irq, 0);
        ar = 1; step();
        chk(acc_s == 0 && cur_p == 8'hFE, "R5 empty accept", acc_s, 0);
        ov = 1; os = 4; op = 8'h10; step();
        chk(nak_v && nak_s == 4, "R6 in-service declined", nak_s, 4);
        ew = 1; ep = 8'h00; es = 4; step();
        chk(cur_p == 8'hFE && rel_v && rel_s == 4, "R7 raise ignored, release", cur_p, 8'hFE);
        ew = 1; ep = 8'hFF; es = 4; step();
        chk(cur_p == 8'hFF && !rel_v, "R7 restore", cur_p, 8'hFF);
        ov = 1; os = 5; op = 8'h40; step();
        pw = 1; pd = 8'h40; step();
        chk(rtn_v && rtn_s == 5 && !irq, "R8 priority write returns", rtn_s, 5);
        pw = 1; pd = 8'hFF; step();
        ov = 1; os = 6; op = 8'h50; step();
        ov = 1; os = 7; op = 8'h30; step();
        chk(rtn_v && rtn_s == 6, "R9 displaced", rtn_s, 6);
        ov = 1; os = 8; op = 8'h30; step();
        chk(nak_v && nak_s == 8, "R9 equal offer declined", nak_s, 8);
        ir = 1; step();
        ar = 1; step();
        chk(acc_s == IPI_S && cur_p == IPI_P && rtn_v && rtn_s == 7, "R10 IPI wins", acc_s, IPI_S);
        ar = 1; ew = 1; ep = 8'hFF; es = IPI_S; step();
        chk(acc_s == 0 && cur_p == IPI_P && !rel_v, "R11 accept over EOI", {acc_s, rel_v}, 0);
        ew = 1; ep = 8'hFF; es = IPI_S; step();
        chk(rel_v && rel_s == IPI_S && cur_p == 8'hFF, "R10 IPI release", rel_s, IPI_S);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            ov = ($urandom_range(0, 9) < 4);
            os = 4'($urandom_range(0, 15));
            op = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 32) * 8);
            ar = ($urandom_range(0, 9) < 2);
            ew = ($urandom_range(0, 9) < 2);
            ep = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
            es = 4'($urandom_range(0, 15));
            pw = ($urandom_range(0, 19) < 2);
            pd = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
            ir = ($urandom_range(0, 19) == 0);
            step();
        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule